// File: doc/BRIEF.md
# Soft-Start Ramp and Gate-Enable Sequencer

This block sequences the start-up of a switching regulator controller. It produces a 6-bit threshold code for the feedback reference DAC. The code begins at full scale and walks down to zero in a fixed staircase. The staircase is paced by a switching-cycle tick, which comes from whichever clock is currently driving the switching: the internal oscillator or an external sync clock. When the staircase has finished, the block raises a done flag.

Three events restart the ramp: power-on reset, leaving shutdown, and the undervoltage flag clearing. During shutdown or undervoltage the gate driver is tri-stated through an output-enable, and the gate level is parked at the switch's inactive level. While the gate is enabled, the PWM request passes to the gate pin. The selected switch polarity decides whether the pin carries the request inverted (P-channel switch, active low) or true (N-channel switch, active high).

Top module: `ssSequencer`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises with no tick yet, `thrCode` is 63 and `ssDone` is 0.
- R2: The code falls by exactly one after every 16 accepted ticks, starting from 63. Cycles without `tick` leave the code and the ramp progress unchanged.
- R3: After 1008 accepted ticks the code is 0, and it stays 0 until the next restart.
- R4: `ssDone` rises on the 1024th accepted tick and stays high until a restart. While `ssDone` is high, the code is 0.
- R5: While `shdnN` is low, the code is held at 63 and `ssDone` at 0. After `shdnN` rises, the first tick is accepted as tick number one.
- R6: While `uvFlag` is high, the code is held at 63 and `ssDone` at 0. After `uvFlag` falls, the first tick is accepted as tick number one.
- R7: `gateOe` is 0 whenever `shdnN` is low or `uvFlag` is high, and 1 otherwise, in the same cycle.
- R8: With `gateOe` high, `gateOut` equals `~pwmIn` when `polNch` is 0 and `pwmIn` when `polNch` is 1, at any point of the ramp.
- R9: With `gateOe` low, `gateOut` is the inactive level: 1 when `polNch` is 0, and 0 when `polNch` is 1.
- R10: A tick in a cycle where shutdown or undervoltage is active is not accepted, and the ramp is reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle pulse per switching cycle |
| shdnN | input | 1 | Active-low shutdown request |
| uvFlag | input | 1 | Undervoltage condition present |
| polNch | input | 1 | 1 selects an N-channel switch (active-high gate) |
| pwmIn | input | 1 | PWM on request from the modulator |
| thrCode | output | 6 | Feedback threshold code for the reference DAC |
| gateOut | output | 1 | Gate drive level |
| gateOe | output | 1 | Gate driver output-enable (0 means tri-state) |
| ssDone | output | 1 | Soft-start ramp completed |

## Verification
Two events can land in the same cycle. The first case is a tick arriving while shutdown or undervoltage is active. The second case is the tick that follows release, which lands in the first cycle after the hold drops. The bench raises shutdown and undervoltage on step-boundary ticks, overlaps them, and releases them with ticks present in every cycle. It also repeats these events with sparse ticks. A behavioural tick counter in the bench predicts the code, the done flag and the gate pins, and the bench compares all of them on every cycle. A reload that is off by one, or an accepted tick during a hold, shows up as a code mismatch.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef struct packed {
    logic clear;    // reload ramp to its start
    logic advance;  // count one accepted tick
    logic outEn;    // gate driver enabled
  } ssStrobes_t;
endpackage

// File: rtl/ssControl.sv
module ssControl
  import ss_pkg::*;
(
  input  logic       tick,
  input  logic       shdnN,
  input  logic       uvFlag,
  output ssStrobes_t strb
);
  logic holdOff;

  always_comb begin
    holdOff      = !shdnN || uvFlag;
    strb.clear   = holdOff;
    strb.advance = tick && !holdOff;
    strb.outEn   = !holdOff;
  end
endmodule

// File: rtl/ssDatapath.sv
module ssDatapath
  import ss_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int STEP_TICKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssStrobes_t        strb,
  input  logic              polNch,
  input  logic              pwmIn,
  output logic [CODE_W-1:0] thrCode,
  output logic              gateOut,
  output logic              ssDone
);
  localparam int PRE_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CODE_W-1:0] CODE_TOP  = {CODE_W{1'b1}};
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_TICKS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [CODE_W-1:0] codeQ;
  logic              doneQ;
  logic              stepEnd;

  assign stepEnd = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      codeQ  <= CODE_TOP;
      doneQ  <= 1'b0;
    end else if (strb.clear) begin
      preCnt <= '0;
      codeQ  <= CODE_TOP;
      doneQ  <= 1'b0;
    end else if (strb.advance && !doneQ) begin
      preCnt <= stepEnd ? '0 : preCnt + 1'b1;
      if (stepEnd) begin
        if (codeQ != '0) codeQ <= codeQ - 1'b1;
        else             doneQ <= 1'b1;
      end
    end
  end

  // Active level: low for P-channel, high for N-channel; inactive when disabled.
  always_comb begin
    if (strb.outEn) gateOut = polNch ? pwmIn : !pwmIn;
    else            gateOut = !polNch;
  end

  assign thrCode = codeQ;
  assign ssDone  = doneQ;

  AST_CLEAR_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (thrCode == CODE_TOP) && !ssDone); // R5

  AST_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> thrCode <= $past(thrCode)); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (thrCode == $past(thrCode)) ||
                     (thrCode == $past(thrCode) - 1'b1)); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear) |=> $stable(thrCode) && $stable(ssDone)); // R2

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ssDone |-> thrCode == '0); // R4
endmodule

// File: rtl/ssSequencer.sv
module ssSequencer
  import ss_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int STEP_TICKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              shdnN,
  input  logic              uvFlag,
  input  logic              polNch,
  input  logic              pwmIn,
  output logic [CODE_W-1:0] thrCode,
  output logic              gateOut,
  output logic              gateOe,
  output logic              ssDone
);
  ssStrobes_t strb;

  ssControl uCtrl (
    .tick   (tick),
    .shdnN  (shdnN),
    .uvFlag (uvFlag),
    .strb   (strb)
  );

  ssDatapath #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .polNch  (polNch),
    .pwmIn   (pwmIn),
    .thrCode (thrCode),
    .gateOut (gateOut),
    .ssDone  (ssDone)
  );

  assign gateOe = strb.outEn;

  AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !gateOe |-> gateOut == !polNch); // R9

  AST_HOLD_TRISTATE: assert property (@(posedge clk) disable iff (!rstN)
    (!shdnN || uvFlag) |-> !gateOe); // R7

  AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (!shdnN || uvFlag) |=> !ssDone); // R10
endmodule

// File: tb/sim_ssSequencer.sv
`timescale 1ns/1ps
module sim_ssSequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0, tick = 1'b0, shdnN = 1'b1, uvFlag = 1'b0, polNch = 1'b0, pwmIn = 1'b0;
  logic [5:0] thrCode;
  logic gateOut, gateOe, ssDone;
  int errors = 0, checks = 0;
  int accTicks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ssSequencer u0 (.clk, .rstN, .tick, .shdnN, .uvFlag, .polNch, .pwmIn,
                  .thrCode, .gateOut, .gateOe, .ssDone);

  // Reference: count of accepted ticks since last restart.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) accTicks <= 0;
    else if (!shdnN || uvFlag) accTicks <= 0;               // R5 R6 R10
    else if (tick && accTicks < 1024) accTicks <= accTicks + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int expCode, expGate, expOe;
    cyc++;
    expCode = (accTicks >= 1008) ? 0 : 63 - accTicks / 16;
    expOe   = (shdnN && !uvFlag) ? 1 : 0;
    expGate = expOe ? (polNch ? pwmIn : !pwmIn) : !polNch;
    if (!rstN) begin
      chk("R1 code", thrCode, 63);
      chk("R1 done", ssDone, 0);
    end else begin
      chk(accTicks >= 1008 ? "R3 code" : "R2 code", thrCode, expCode);
      chk("R4 done", ssDone, (accTicks >= 1024) ? 1 : 0);
      chk("R7 oe", gateOe, expOe);
      chk(expOe ? "R8 gate" : "R9 gate", gateOut, expGate);
    end
  end

  // tickGap: 1 = tick every cycle, n = one tick every n cycles
  task automatic runCycles(input int n, input int tickGap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick  = (tickGap > 0) && ((i % tickGap) == 0);
      pwmIn = $urandom_range(0, 1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    runCycles(5, 1);                 // R1 ticks during reset are ignored
    @(posedge clk); #1 rstN = 1'b1; tick = 1'b0;
    runCycles(10, 0);                // R1/R2 idle after reset
    runCycles(1100, 1);              // R2 R3 R4 full ramp, P-channel
    polNch = 1'b1;
    runCycles(50, 1);                // R8 N-channel after done
    @(posedge clk); #1 shdnN = 1'b0; // R5 restart
    runCycles(30, 1);                // R9/R10 ticks under shutdown
    @(posedge clk); #1 shdnN = 1'b1;
    runCycles(303, 1);
    @(posedge clk); #1 uvFlag = 1'b1; // R6 mid-ramp
    runCycles(20, 1);
    @(posedge clk); #1 uvFlag = 1'b0;
    runCycles(160, 1);               // aligned to step boundary
    @(posedge clk); #1 uvFlag = 1'b1; shdnN = 1'b0; // overlap
    runCycles(8, 1);
    @(posedge clk); #1 uvFlag = 1'b0;
    runCycles(8, 1);
    @(posedge clk); #1 shdnN = 1'b1;
    polNch = 1'b0;
    runCycles(3200, 3);              // R2 sparse ticks, full ramp
    @(posedge clk); #1 uvFlag = 1'b1;
    runCycles(4, 0);
    @(posedge clk); #1 uvFlag = 1'b0;
    runCycles(600, 2);
    @(posedge clk); #1 rstN = 1'b0;  // R1 power cycle mid-ramp
    runCycles(3, 1);
    @(posedge clk); #1 rstN = 1'b1;
    runCycles(1200, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule